// File: doc/BRIEF.md
# SPI Streaming Register Access Engine

This block is an SPI slave front end that gives a host byte-wide access to a register file through frames. Each frame opens with a 16-bit instruction phase that carries a read/write flag and a starting address. A data phase follows and can run for any number of bytes. SCLK, CS_n and SDI are oversampled on the system clock. Register-file writes appear as single-cycle strobes. Read data is taken from a combinational read port that follows the engine's working address.

Three controls shape a frame, and the engine captures them at the moment the instruction phase completes. The single-access control limits the frame to one register byte. The direction control picks whether the working address counts up or down after each byte. The loop length folds the working address back to the starting address after a set number of bytes, so a host can sweep the same group of adjacent registers over and over inside one frame. In the upper address region the count always runs downward. For multibyte registers this has a fixed meaning. In ascending mode the host addresses the least significant byte and data moves LSB first. In descending mode the host addresses the most significant byte and data moves MSB first.

Top module: `spi_stream_engine`

## Requirements
- R1: While reset is active or CS_n is high, rf_wen stays low and sdo_oe is low. sdo_oe is high exactly while CS_n is low.
- R2: The instruction phase is the first 16 SDI bits of a frame, taken on rising SCLK edges, MSB first. Bit 15 set to 1 means read and 0 means write. Bits 14:0 are the starting address.
- R3: In a write frame, each complete data byte (8 bits, MSB first) produces exactly one single-cycle rf_wen pulse. The pulse carries that byte on rf_wdata and the byte's address on rf_waddr.
- R4: With cfg_descend low, and a start address below the upper region, the address of each following byte is the previous address plus one.
- R5: With cfg_descend high, the address of each following byte is the previous address minus one, modulo 2^15 (0x0000 is followed by 0x7FFF).
- R6: With cfg_single high at the end of the instruction phase, only the first data byte is accessed. Later bytes produce no rf_wen pulse and read back as 0x00 on SDO.
- R7: A loop length N other than 0 returns the address to the starting address after every N bytes. A loop length of 0 never returns it.
- R8: A start address of 0x29 or higher forces descending stepping, whatever the value of cfg_descend.
- R9: In a read frame, each data byte is the rf_rdata value at that byte's address. It is driven on sdo MSB first, with each bit changing after a falling SCLK edge, so the host samples it on the next rising edge.
- R10: Raising CS_n at any point ends the frame. A partly shifted byte is dropped and never written, and the next frame starts again with a fresh instruction phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host (idles low, mode 0) |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host (0 when not enabled) |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |
| cfg_single | input | 1 | 1 limits a frame to one register byte, 0 streams |
| cfg_descend | input | 1 | 1 steps the address down, 0 steps it up |
| cfg_loop_len | input | 8 | Loop length in bytes; 0 disables looping |
| rf_raddr | output | 15 | Register-file read address (working address) |
| rf_rdata | input | 8 | Register-file read data for rf_raddr |
| rf_wen | output | 1 | Single-cycle register-file write strobe |
| rf_waddr | output | 15 | Register-file write address |
| rf_wdata | output | 8 | Register-file write data |

## Verification
The bench builds the block with its defaults: a 15-bit address, an 8-bit loop length, the upper region starting at 0x29, two synchronizer stages and looping compiled in. The 15-bit width lets a two-byte descending frame from 0x0000 reach the 0x7FFF wrap. The low 0x29 boundary lets short frames cross into the forced-descending region and also run loop windows there. With two synchronizer stages and six system clocks per SCLK half period, there is a known, fixed margin between each detected SCLK edge and the point at which the bench samples SDO.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;

   typedef enum logic {
      PH_INSTR = 1'b0,
      PH_DATA  = 1'b1
   } phase_e;

   typedef struct packed {
      logic sclk;
      logic cs_n;
      logic sdi;
   } pin_s;

   localparam pin_s PIN_IDLE = '{sclk: 1'b0, cs_n: 1'b1, sdi: 1'b0};

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync
   import spi_stream_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic sdi,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_act,
   output logic sdi_s
);

   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_stages
         $error("spi_edge_sync: SYNC_STAGES must lie in 1..4");
      end
   endgenerate

   pin_s pipe_q [SYNC_STAGES];
   logic sclk_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) pipe_q[i] <= PIN_IDLE;
         sclk_prev_q <= 1'b0;
      end else begin
         pipe_q[0] <= '{sclk: sclk, cs_n: cs_n, sdi: sdi};
         for (int i = 1; i < SYNC_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
         sclk_prev_q <= pipe_q[SYNC_STAGES-1].sclk;
      end
   end

   assign sclk_rise = pipe_q[SYNC_STAGES-1].sclk & ~sclk_prev_q;
   assign sclk_fall = ~pipe_q[SYNC_STAGES-1].sclk & sclk_prev_q;
   assign cs_act    = ~pipe_q[SYNC_STAGES-1].cs_n;
   assign sdi_s     = pipe_q[SYNC_STAGES-1].sdi;

endmodule

// File: rtl/spi_addr_gen.sv
module spi_addr_gen #(
   parameter int          ADDR_W       = 15,
   parameter int          LEN_W        = 8,
   parameter int unsigned HI_BASE      = 32'h29,
   parameter bit          LOOP_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              cfg_descend,
   input  logic [LEN_W-1:0]  cfg_loop_len,
   output logic [ADDR_W-1:0] cur_addr
);

   localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(HI_BASE);

   logic [ADDR_W-1:0] base_q, cur_q;
   logic [LEN_W-1:0]  len_q, idx_q;
   logic              desc_q;
   logic              wrap_now;

   generate
      if (LOOP_SUPPORT) begin : g_loop
         assign wrap_now = (len_q != '0) && (idx_q == len_q - LEN_W'(1));

         // Window index never reaches the programmed length (R7)
         assert_window_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (len_q != '0) |-> (idx_q < len_q));
      end else begin : g_free
         assign wrap_now = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
         len_q  <= '0;
         idx_q  <= '0;
         desc_q <= (HI_ADDR == '0);
      end else if (load) begin
         base_q <= start_addr;
         cur_q  <= start_addr;
         len_q  <= cfg_loop_len;
         idx_q  <= '0;
         desc_q <= cfg_descend || (start_addr >= HI_ADDR);
      end else if (step) begin
         if (wrap_now) begin
            cur_q <= base_q;
            idx_q <= '0;
         end else begin
            cur_q <= desc_q ? cur_q - ADDR_W'(1) : cur_q + ADDR_W'(1);
            idx_q <= idx_q + LEN_W'(1);
         end
      end
   end

   assign cur_addr = cur_q;

   // A frame based in the upper region always steps downward (R8)
   assert_upper_descends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (base_q >= HI_ADDR) |-> desc_q);

endmodule

// File: rtl/spi_stream_engine.sv
module spi_stream_engine
   import spi_stream_pkg::*;
#(
   parameter int          ADDR_W       = 15,
   parameter int          LEN_W        = 8,
   parameter int unsigned HI_BASE      = 32'h29,
   parameter int          SYNC_STAGES  = 2,
   parameter bit          LOOP_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic              cfg_single,
   input  logic              cfg_descend,
   input  logic [LEN_W-1:0]  cfg_loop_len,
   output logic [ADDR_W-1:0] rf_raddr,
   input  logic [7:0]        rf_rdata,
   output logic              rf_wen,
   output logic [ADDR_W-1:0] rf_waddr,
   output logic [7:0]        rf_wdata
);

   localparam int INSTR_W = ADDR_W + 1;
   localparam int CNT_W   = $clog2(INSTR_W);

   generate
      if (ADDR_W < 8 || ADDR_W > 30) begin : g_bad_addr
         $error("spi_stream_engine: ADDR_W must lie in 8..30");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("spi_stream_engine: LEN_W must lie in 1..16");
      end
      if (HI_BASE >= (32'd1 << ADDR_W)) begin : g_bad_hi
         $error("spi_stream_engine: HI_BASE outside the address space");
      end
   endgenerate

   logic sclk_rise, sclk_fall, cs_act, sdi_s;

   spi_edge_sync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk      (sclk),
      .cs_n      (cs_n),
      .sdi       (sdi),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .cs_act    (cs_act),
      .sdi_s     (sdi_s)
   );

   phase_e             phase_q;
   logic [CNT_W-1:0]   bit_cnt_q;
   logic [INSTR_W-1:0] in_sr_q;
   logic [7:0]         out_sr_q;
   logic               is_read_q, single_q, done_q;
   logic               instr_last, byte_last, step_addr;
   logic [ADDR_W-1:0]  start_addr, cur_addr;

   always_comb begin
      instr_last = sclk_rise && cs_act && (phase_q == PH_INSTR)
                   && (bit_cnt_q == CNT_W'(INSTR_W - 1));
      byte_last  = sclk_rise && cs_act && (phase_q == PH_DATA)
                   && (bit_cnt_q == CNT_W'(7));
      step_addr  = byte_last && !single_q;
      start_addr = {in_sr_q[ADDR_W-2:0], sdi_s};
   end

   spi_addr_gen #(
      .ADDR_W       (ADDR_W),
      .LEN_W        (LEN_W),
      .HI_BASE      (HI_BASE),
      .LOOP_SUPPORT (LOOP_SUPPORT)
   ) u_addr (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (instr_last),
      .step         (step_addr),
      .start_addr   (start_addr),
      .cfg_descend  (cfg_descend),
      .cfg_loop_len (cfg_loop_len),
      .cur_addr     (cur_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_INSTR;
         bit_cnt_q <= '0;
         in_sr_q   <= '0;
         out_sr_q  <= '0;
         is_read_q <= 1'b0;
         single_q  <= 1'b0;
         done_q    <= 1'b0;
         rf_wen    <= 1'b0;
         rf_waddr  <= '0;
         rf_wdata  <= '0;
      end else if (!cs_act) begin
         phase_q   <= PH_INSTR;
         bit_cnt_q <= '0;
         out_sr_q  <= '0;
         done_q    <= 1'b0;
         rf_wen    <= 1'b0;
      end else begin
         rf_wen <= 1'b0;
         if (sclk_rise) begin
            in_sr_q <= {in_sr_q[INSTR_W-2:0], sdi_s};
            if (instr_last) begin
               phase_q   <= PH_DATA;
               bit_cnt_q <= '0;
               is_read_q <= in_sr_q[INSTR_W-2];
               single_q  <= cfg_single;
            end else if (byte_last) begin
               bit_cnt_q <= '0;
               if (!is_read_q && !done_q) begin
                  rf_wen   <= 1'b1;
                  rf_waddr <= cur_addr;
                  rf_wdata <= {in_sr_q[6:0], sdi_s};
               end
               if (single_q) done_q <= 1'b1;
            end else begin
               bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            end
         end else if (sclk_fall && (phase_q == PH_DATA)) begin
            if (bit_cnt_q == '0) out_sr_q <= (is_read_q && !done_q) ? rf_rdata : 8'h00;
            else                 out_sr_q <= {out_sr_q[6:0], 1'b0};
         end
      end
   end

   assign rf_raddr = cur_addr;
   assign sdo_oe   = ~cs_n;
   assign sdo      = out_sr_q[7];

   // Write strobes are one cycle wide (R3)
   assert_wen_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wen |=> !rf_wen);

   // A strobe only follows a cycle with the frame selected (R1)
   assert_wen_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wen |-> $past(cs_act));

   // Deselect silences the write port on the next cycle (R10)
   assert_abort_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !rf_wen);

   // Once the single access is spent, no further strobe (R6)
   assert_single_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done_q) |-> !rf_wen);

endmodule

// File: tb/test_spi_stream_engine.sv
`timescale 1ns/1ps
module test_spi_stream_engine;

   localparam int HALF = 6;

   typedef struct packed {
      logic        rw;
      logic [14:0] addr;
      logic        desc;
      logic        single;
      logic [7:0]  len;
      logic [3:0]  nb;
      logic [14:0] last;
      logic [3:0]  tag;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 15'h0010, 1'b0, 1'b0, 8'd0, 4'd3, 15'h0012, 4'd4},
      '{1'b0, 15'h0020, 1'b1, 1'b0, 8'd0, 4'd3, 15'h001E, 4'd5},
      '{1'b0, 15'h002C, 1'b0, 1'b0, 8'd4, 4'd6, 15'h002B, 4'd8},
      '{1'b0, 15'h0005, 1'b0, 1'b1, 8'd0, 4'd3, 15'h0005, 4'd6},
      '{1'b0, 15'h0040, 1'b0, 1'b0, 8'd2, 4'd5, 15'h0040, 4'd7},
      '{1'b0, 15'h0000, 1'b1, 1'b0, 8'd0, 4'd2, 15'h7FFF, 4'd5},
      '{1'b1, 15'h002C, 1'b1, 1'b0, 8'd4, 4'd5, 15'h002C, 4'd9},
      '{1'b1, 15'h0005, 1'b0, 1'b1, 8'd0, 4'd2, 15'h0005, 4'd6},
      '{1'b1, 15'h0010, 1'b0, 1'b0, 8'd0, 4'd3, 15'h0012, 4'd2},
      '{1'b1, 15'h0012, 1'b1, 1'b0, 8'd2, 4'd4, 15'h0011, 4'd7}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
   logic        cfg_single = 1'b0, cfg_descend = 1'b0;
   logic [7:0]  cfg_loop_len = 8'd0;
   logic        sdo, sdo_oe, rf_wen;
   logic [14:0] rf_raddr, rf_waddr;
   logic [7:0]  rf_wdata, rf_rdata;

   logic [7:0]  mem [128];
   logic [7:0]  exp_mem [128];
   logic [14:0] wlog_a [64];
   logic [7:0]  wlog_d [64];
   int          wtotal = 0;
   int          n_chk = 0, n_fail = 0;
   bit          finished = 1'b0;
   logic [14:0] seq [16];
   logic [7:0]  rx [16];

   always #4 clk = ~clk;

   spi_stream_engine i_spi_stream_engine (
      .clk (clk), .rst_n (rst_n), .sclk (sclk), .cs_n (cs_n), .sdi (sdi),
      .sdo (sdo), .sdo_oe (sdo_oe), .cfg_single (cfg_single),
      .cfg_descend (cfg_descend), .cfg_loop_len (cfg_loop_len),
      .rf_raddr (rf_raddr), .rf_rdata (rf_rdata), .rf_wen (rf_wen),
      .rf_waddr (rf_waddr), .rf_wdata (rf_wdata)
   );

   assign rf_rdata = mem[rf_raddr[6:0]];

   always @(posedge clk) begin
      if (rf_wen) begin
         mem[rf_waddr[6:0]]   <= rf_wdata;
         wlog_a[wtotal % 64]  <= rf_waddr;
         wlog_d[wtotal % 64]  <= rf_wdata;
         wtotal               <= wtotal + 1;
      end
   end

   function automatic string tname(input logic [3:0] t);
      case (t)
         4'd2: return "R2";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         4'd7: return "R7";
         4'd8: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic spi_bit(input logic b, output logic r);
      @(negedge clk);
      sdi = b;
      repeat (HALF) @(negedge clk);
      r = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rv);
      logic r;
      for (int b = 7; b >= 0; b--) begin
         spi_bit(tx[b], r);
         rv[b] = r;
      end
   endtask

   task automatic frame_begin(input logic rw, input logic [14:0] a);
      logic [7:0] dump;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      xfer_byte({rw, a[14:8]}, dump);
      xfer_byte(a[7:0], dump);
   endtask

   task automatic frame_end();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (4 * HALF) @(negedge clk);
   endtask

   // Address sequence from the stepping rules (R4, R5, R7, R8)
   task automatic model_seq(input vec_t v);
      logic [14:0] a = v.addr;
      int          idx = 0;
      bit          dn = v.desc || (v.addr >= 15'h0029);
      for (int i = 0; i < 16; i++) begin
         seq[i] = a;
         if (v.len != 0 && idx == int'(v.len) - 1) begin
            a = v.addr;
            idx = 0;
         end else begin
            a = dn ? a - 15'd1 : a + 15'd1;
            idx++;
         end
      end
   endtask

   initial begin
      for (int i = 0; i < 128; i++) exp_mem[i] = 8'h00;
      repeat (5) @(negedge clk);
      // R1: reset holds the write port idle and SDO disabled
      check(rf_wen == 1'b0, "R1 wen during reset", {31'd0, rf_wen}, 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(sdo_oe == 1'b0, "R1 sdo_oe idle", {31'd0, sdo_oe}, 32'd0);
      check(rf_wen == 1'b0, "R1 wen idle", {31'd0, rf_wen}, 32'd0);

      for (int vi = 0; vi < NV; vi++) begin
         vec_t v = VEC[vi];
         int   base;
         int   nw;
         logic [7:0] d;
         model_seq(v);
         cfg_single = v.single;
         cfg_descend = v.desc;
         cfg_loop_len = v.len;
         base = wtotal;
         frame_begin(v.rw, v.addr);
         check(sdo_oe == 1'b1, "R1 sdo_oe in frame", {31'd0, sdo_oe}, 32'd1);
         for (int i = 0; i < int'(v.nb); i++) begin
            d = 8'h30 + 8'(vi * 16) + 8'(i);
            xfer_byte(d, rx[i]);
         end
         frame_end();
         if (!v.rw) begin
            nw = v.single ? 1 : int'(v.nb);
            check(wtotal - base == nw, {tname(v.tag), " R3 write count"}, 32'(wtotal - base), 32'(nw));
            for (int i = 0; i < nw; i++) begin
               d = 8'h30 + 8'(vi * 16) + 8'(i);
               check(wlog_a[(base + i) % 64] == seq[i], {tname(v.tag), " write address"},
                     32'(wlog_a[(base + i) % 64]), 32'(seq[i]));
               check(wlog_d[(base + i) % 64] == d, "R3 write data",
                     32'(wlog_d[(base + i) % 64]), 32'(d));
               exp_mem[seq[i][6:0]] = d;
            end
            check(wlog_a[(base + nw - 1) % 64] == v.last, {tname(v.tag), " last address"},
                  32'(wlog_a[(base + nw - 1) % 64]), 32'(v.last));
         end else begin
            check(wtotal == base, "R2 read frame writes nothing", 32'(wtotal - base), 32'd0);
            for (int i = 0; i < int'(v.nb); i++) begin
               logic [7:0] e;
               e = (v.single && i > 0) ? 8'h00 : exp_mem[seq[i][6:0]];
               check(rx[i] === e, {tname(v.tag), " read byte"}, 32'(rx[i]), 32'(e));
            end
         end
         check(sdo_oe == 1'b0, "R1 sdo_oe after frame", {31'd0, sdo_oe}, 32'd0);
      end

      // R10: abort inside a data byte drops it
      cfg_single = 1'b0; cfg_descend = 1'b0; cfg_loop_len = 8'd0;
      begin
         int   base;
         logic r;
         base = wtotal;
         frame_begin(1'b0, 15'h0011);
         for (int b = 0; b < 5; b++) spi_bit(1'b1, r);
         frame_end();
         check(wtotal == base, "R10 partial byte written", 32'(wtotal - base), 32'd0);
         frame_begin(1'b1, 15'h0011);
         xfer_byte(8'h00, rx[0]);
         frame_end();
         check(rx[0] === exp_mem[7'h11], "R10 register kept", 32'(rx[0]), 32'(exp_mem[7'h11]));
         // R10: abort inside the instruction phase restarts cleanly
         @(negedge clk);
         cs_n = 1'b0;
         for (int b = 0; b < 9; b++) spi_bit(1'b1, r);
         frame_end();
         base = wtotal;
         frame_begin(1'b0, 15'h000A);
         xfer_byte(8'h5C, rx[0]);
         frame_end();
         check(wtotal - base == 1, "R10 restart write count", 32'(wtotal - base), 32'd1);
         check(wlog_a[base % 64] == 15'h000A, "R10 restart address", 32'(wlog_a[base % 64]), 32'h0A);
         check(wlog_d[base % 64] == 8'h5C, "R10 restart data", 32'(wlog_d[base % 64]), 32'h5C);
      end

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=done");
         summary();
         $finish;
      end
   end

endmodule